// File: doc/BRIEF.md
# Up/Down Event Timer with Quadrature and Cascade Clocking

This block is a 16-bit up/down counter that serves as the time base of an event processor. One of four count sources feeds it. The first is the core clock through a power-of-two divider. The second is the rising edge of an external clock pin through the same divider. The third is a quadrature pair formed by the clock pin and a direction pin. The fourth is the overflow pulse of a companion timer, so two timers can be chained into a wider count. Both pins are asynchronous and pass through two-flop synchronisers before any edge is detected.

The block is configured through a set of static inputs: source select, divider exponent and count direction. Software can write a new count value with a one-cycle strobe. A compare channel can clear the count synchronously. The block outputs the current count and a one-cycle pulse on each wrap. The companion timer can take that pulse as its cascade input.

Top module: `evt_timer`

## Requirements
- R1: After `rst_n` is released, `count` is 0 and `ovf_pulse` is 0 until the first count step.
- R2: With `cfg_mode` = 0 (core clock), the count takes one step every 2^n cycles, where n = `cfg_prescale`. Values 0 to 6 are valid, and the value 7 behaves as 6.
- R3: In modes 0, 1 and 3, each step adds 1 when `cfg_dir_down` = 0 and subtracts 1 when `cfg_dir_down` = 1. The count wraps modulo 2^16.
- R4: With `cfg_mode` = 1 (external clock), each rising edge of `pin_clk` is one divider input, and the divider is the same 2^n divider as in R2. A rising edge appears on `count` within four cycles. Each pin level must be held for at least two cycles.
- R5: With `cfg_mode` = 2 (quadrature), each change of exactly one of `pin_clk` and `pin_dir` is one step. The (`pin_clk`,`pin_dir`) sequence 00→10→11→01→00 counts up, and the reverse sequence counts down.
- R6: In quadrature mode, a change of both pins between two synchronised samples leaves the count unchanged.
- R7: With `cfg_mode` = 3 (cascade), each cycle in which `casc_ovf` is high is one step, with no divider.
- R8: `ovf_pulse` is high for exactly the one cycle in which the count has just stepped from FFFF to 0 going up, or from 0 to FFFF going down. It is low at all other times.
- R9: When `wr_count` is high at a clock edge, `count` takes the value of `wr_data` at that edge. No step happens in that cycle and no overflow pulse is produced.
- R10: When `cmp_reset` is high at a clock edge, `count` becomes 0 and `ovf_pulse` stays low. This takes priority over a load and over a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Count source: 0 core clock, 1 external pin, 2 quadrature, 3 cascade |
| cfg_prescale | input | 3 | Divider exponent n for modes 0 and 1 |
| cfg_dir_down | input | 1 | Count direction outside quadrature mode (1 = down) |
| wr_count | input | 1 | Load strobe for the count value |
| wr_data | input | 16 | Value to load |
| cmp_reset | input | 1 | Synchronous clear request from a compare channel |
| casc_ovf | input | 1 | Overflow pulse from the companion timer |
| pin_clk | input | 1 | Asynchronous external clock / quadrature A pin |
| pin_dir | input | 1 | Asynchronous direction / quadrature B pin |
| count | output | 16 | Current count |
| ovf_pulse | output | 1 | One-cycle wrap pulse |

## Verification
The hardest behaviour to reach from the ports is quadrature decoding under arbitrary back-and-forth motion, including illegal jumps where both pins change together. Each pin change only reaches the counter after three register stages. The stimulus is a seeded random walk over the four quadrature states: it steps forward, steps back, jumps two states or holds. Each state is held long enough for the synchroniser to sample it, and the bench sums the legal moves to predict the final count. The wrap pulse is reached with directed loads of FFFF and 0 just before a step in each direction.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    SRC_CORE = 2'd0,
    SRC_PIN  = 2'd1,
    SRC_QUAD = 2'd2,
    SRC_CASC = 2'd3
  } src_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta   <= 1'b0;
        stable <= 1'b0;
      end else begin
        meta   <= d_async[i];
        stable <= meta;
      end
    end
    assign d_sync[i] = stable;
  end
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter  int PRE_MAX = 6,
  localparam int SEL_W   = $clog2(PRE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_in,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_MAX-1:0] pcnt;
  logic [PRE_MAX-1:0] mask;

  // Low-bit mask of width n, with n clamped to PRE_MAX.
  function automatic logic [PRE_MAX-1:0] div_mask(input logic [SEL_W-1:0] s);
    int n;
    logic [PRE_MAX-1:0] m;
    n = (int'(s) > PRE_MAX) ? PRE_MAX : int'(s);
    for (int i = 0; i < PRE_MAX; i++) m[i] = (i < n);
    return m;
  endfunction

  assign mask = div_mask(sel);
  assign tick = ev_in && ((pcnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt <= '0;
    else if (ev_in) pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/evt_quad.sv
module evt_quad (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic step,
  output logic up,
  output logic both,
  output logic a_rise
);
  logic a_q, b_q, a_chg, b_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a;
      b_q <= b;
    end
  end

  assign a_chg  = a ^ a_q;
  assign b_chg  = b ^ b_q;
  assign step   = a_chg ^ b_chg;
  assign both   = a_chg & b_chg;
  // Up when A leads B: new A differs from old B.
  assign up     = a ^ b_q;
  assign a_rise = a & ~a_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter  int CW      = 16,
  parameter  int PRE_MAX = 6,
  localparam int SEL_W   = $clog2(PRE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [SEL_W-1:0] cfg_prescale,
  input  logic             cfg_dir_down,
  input  logic             wr_count,
  input  logic [CW-1:0]    wr_data,
  input  logic             cmp_reset,
  input  logic             casc_ovf,
  input  logic             pin_clk,
  input  logic             pin_dir,
  output logic [CW-1:0]    count,
  output logic             ovf_pulse
);
  src_e       mode;
  logic [1:0] pins_s;
  logic       q_step, q_up, q_both, clk_rise;
  logic       pre_ev, pre_tick;
  logic       step_en, step_up, quad_mode;
  logic [CW:0] nxt;

  // Returns {wrap, next value}.
  function automatic logic [CW:0] advance(input logic [CW-1:0] cur, input logic dir_up);
    logic wrap;
    wrap = dir_up ? (&cur) : ~(|cur);
    return {wrap, dir_up ? cur + 1'b1 : cur - 1'b1};
  endfunction

  assign mode = src_e'(cfg_mode);

  evt_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({pin_dir, pin_clk}), .d_sync(pins_s)
  );

  evt_quad u_quad (
    .clk(clk), .rst_n(rst_n), .a(pins_s[0]), .b(pins_s[1]),
    .step(q_step), .up(q_up), .both(q_both), .a_rise(clk_rise)
  );

  always_comb begin
    case (mode)
      SRC_CORE: pre_ev = 1'b1;
      SRC_PIN:  pre_ev = clk_rise;
      default:  pre_ev = 1'b0;
    endcase
  end

  evt_prescaler #(.PRE_MAX(PRE_MAX)) u_pre (
    .clk(clk), .rst_n(rst_n), .ev_in(pre_ev), .sel(cfg_prescale), .tick(pre_tick)
  );

  assign quad_mode = (mode == SRC_QUAD);

  always_comb begin
    case (mode)
      SRC_QUAD: step_en = q_step;
      SRC_CASC: step_en = casc_ovf;
      default:  step_en = pre_tick;
    endcase
    step_up = quad_mode ? q_up : ~cfg_dir_down;
  end

  assign nxt = advance(count, step_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      ovf_pulse <= 1'b0;
    end else if (cmp_reset) begin
      count     <= '0;
      ovf_pulse <= 1'b0;
    end else if (wr_count) begin
      count     <= wr_data;
      ovf_pulse <= 1'b0;
    end else if (step_en) begin
      count     <= nxt[CW-1:0];
      ovf_pulse <= nxt[CW];
    end else begin
      ovf_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmp_reset,
  input logic          wr_count,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] count,
  input logic          ovf_pulse,
  input logic          step_en,
  input logic          step_up,
  input logic          q_both,
  input logic          quad_mode
);
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_reset |=> (count == '0) && !ovf_pulse);

  a_r9_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_count && !cmp_reset) |=> (count == $past(wr_data)) && !ovf_pulse);

  a_r8_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ((count == '0) && ($past(count) == '1)) ||
                  ((count == '1) && ($past(count) == '0)));

  a_r3_step_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !cmp_reset && !wr_count) |=>
      (count == ($past(step_up) ? CW'($past(count) + 1'b1) : CW'($past(count) - 1'b1))));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !cmp_reset && !wr_count) |=> $stable(count) && !ovf_pulse);

  a_r6_double_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_mode && q_both && !cmp_reset && !wr_count) |=> $stable(count));
endmodule

bind evt_timer evt_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_reset(cmp_reset), .wr_count(wr_count),
  .wr_data(wr_data), .count(count), .ovf_pulse(ovf_pulse), .step_en(step_en),
  .step_up(step_up), .q_both(q_both), .quad_mode(quad_mode)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd3;
  logic [2:0]  cfg_prescale = 3'd0;
  logic        cfg_dir_down = 1'b0;
  logic        wr_count = 1'b0;
  logic [15:0] wr_data = '0;
  logic        cmp_reset = 1'b0;
  logic        casc_ovf = 1'b0;
  logic        pin_clk = 1'b0;
  logic        pin_dir = 1'b0;
  logic [15:0] count;
  logic        ovf_pulse;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_timer u_dut (.*);

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic load(input logic [15:0] v);
    wr_count = 1'b1; wr_data = v;
    cyc();
    wr_count = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(2); rst_n = 1'b1;
  endtask

  // Quadrature state order {clk,dir}: 00,10,11,01 (forward = up).
  function automatic logic [1:0] qstate(input int idx);
    case (idx & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic int clamp_n(input int n);
    return (n > 6) ? 6 : n;
  endfunction

  task automatic pulse_pin(input int k);
    for (int i = 0; i < k; i++) begin
      pin_clk = 1'b1; cyc(2); pin_clk = 1'b0; cyc(2);
    end
    cyc(4);
  endtask

  initial begin
    logic [15:0] c0;
    int qidx, exp_q;
    void'($urandom(32'd1357));
    cyc(3); rst_n = 1'b1; cyc(3);
    // R1: cascade mode with no input: stays at reset value
    check("R1 count", count, 0);
    check("R1 ovf", ovf_pulse, 0);

    // R9 load in idle
    load(16'h1234);
    check("R9 load", count, 16'h1234);

    // R2/R3 core clock n=0 up
    cfg_mode = 2'd0; c0 = count; cyc(10);
    check("R2 n0 rate", 16'(count - c0), 10);
    // R9 load while counting suppresses step
    load(16'h00FF);
    check("R9 no step on load", count, 16'h00FF);
    check("R9 no ovf", ovf_pulse, 0);

    // R8 up wrap
    load(16'hFFFF);
    check("R8 before wrap", ovf_pulse, 0);
    cyc();
    check("R8 up wrap count", count, 0);
    check("R8 up wrap ovf", ovf_pulse, 1);
    cyc();
    check("R8 pulse one cycle", ovf_pulse, 0);

    // R3/R8 down wrap
    cfg_dir_down = 1'b1;
    load(16'h0000);
    cyc();
    check("R3 down count", count, 16'hFFFF);
    check("R8 down wrap ovf", ovf_pulse, 1);
    cyc();
    check("R3 down step", count, 16'hFFFE);
    cfg_dir_down = 1'b0;

    // R10 priority over load and step
    cmp_reset = 1'b1; wr_count = 1'b1; wr_data = 16'hABCD;
    cyc();
    cmp_reset = 1'b0; wr_count = 1'b0;
    check("R10 clear over load", count, 0);
    check("R10 no ovf", ovf_pulse, 0);

    // R2 prescale rates, including 7 acting as 6
    for (int n = 0; n < 8; n++) begin
      cfg_prescale = 3'(n);
      cfg_dir_down = n[0];
      cyc(64);
      c0 = count;
      cyc(8 << clamp_n(n));
      if (n[0]) check("R2 down rate", 16'(c0 - count), 8);
      else      check("R2 up rate", 16'(count - c0), 8);
    end
    cfg_dir_down = 1'b0;

    // R4 external pin with divide by 4 from a fresh divider
    cfg_mode = 2'd1; cfg_prescale = 3'd2; do_reset();
    pulse_pin(8);
    check("R4 ext div4", count, 2);
    cfg_prescale = 3'd0; cfg_dir_down = 1'b1;
    pulse_pin(3);
    check("R4 ext down", count, 16'hFFFF);
    cfg_dir_down = 1'b0;

    // R7 cascade, down through zero
    cfg_mode = 2'd3; cfg_dir_down = 1'b1;
    load(16'h0002);
    for (int i = 0; i < 2; i++) begin
      casc_ovf = 1'b1; cyc(); casc_ovf = 1'b0; cyc(2);
    end
    check("R7 cascade steps", count, 0);
    casc_ovf = 1'b1; cyc(); casc_ovf = 1'b0;
    cyc();
    check("R7 cascade wrap", count, 16'hFFFF);
    cfg_dir_down = 1'b0;
    casc_ovf = 1'b1; cyc(); casc_ovf = 1'b0;
    check("R8 cascade up wrap ovf", ovf_pulse, 1);
    check("R7 cascade up", count, 0);

    // R5 directed quadrature: four forward steps
    cfg_mode = 2'd2; load(16'h0100);
    qidx = 0;
    for (int i = 0; i < 4; i++) begin
      qidx++; {pin_clk, pin_dir} = qstate(qidx); cyc(3);
    end
    cyc(4);
    check("R5 quad forward", count, 16'h0104);
    for (int i = 0; i < 2; i++) begin
      qidx--; {pin_clk, pin_dir} = qstate(qidx); cyc(3);
    end
    cyc(4);
    check("R5 quad reverse", count, 16'h0102);
    // R6 double jump
    qidx += 2; {pin_clk, pin_dir} = qstate(qidx); cyc(7);
    check("R6 double ignored", count, 16'h0102);

    // R5/R6 random walk
    load(16'h8000); exp_q = 0;
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 4)      begin qidx++; exp_q++; end
      else if (r < 7) begin qidx--; exp_q--; end
      else if (r < 9) qidx += 2;
      {pin_clk, pin_dir} = qstate(qidx);
      cyc(3);
    end
    cyc(4);
    check("R5 R6 random quad", count, 16'(32'h8000 + exp_q));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule